// File: doc/BRIEF.md
# Synchronous Burst-Write Host Bus Target

This block is the receiving end of a clocked host bus that carries address and data on separate lines. It accepts 16-bit random burst writes, in which the host presents a fresh address alongside every data word. Chip select and data strobe are both active low and must stay low for the whole burst. The direction select, the memory-or-register select and two byte-enable bits qualify the transfer. An active-low final-word flag marks the last word.

Once the host opens a write, the block waits a fixed, parameterised number of cycles before it pulls its active-low ready output low. It takes nothing from the bus during that first ready cycle. From the next edge onwards it takes one word per clock. Each word it takes is handed to an internal write port as a one-cycle write pulse, together with the address, the data and the memory/register flag. A full input from a downstream command queue drives the active-low stop output and stalls the burst without losing the word the host is holding. If the host lets go of select or strobe early, the burst is abandoned.

Top module: `hbw_slave`

## Requirements
- R1: After reset, hb_rdy_n and hb_stop_n are high and wr_en is low.
- R2: A write opens when hb_sel_n and hb_strb_n are both low, hb_rd_wr_n is 0 (write) and both hb_wen bits are 1. hb_rdy_n first goes low exactly LAT clock edges after the first edge that samples this condition.
- R3: No word is taken at the edge that ends the first ready-low cycle. After that, one word is taken at each edge while hb_rdy_n is low, and a word is only ever taken while hb_rdy_n is low.
- R4: Each word taken yields wr_en high for exactly the following cycle. In that cycle wr_addr, wr_data and wr_mem hold the hb_addr, hb_data and hb_mem_reg_n values sampled at the same edge (hb_mem_reg_n 1 = memory, 0 = register).
- R5: A word taken with hb_last_n low is the final one, and hb_rdy_n is high from that edge. No further word is taken, and ready stays high until select or strobe has been released.
- R6: A write whose hb_wen is not 2'b11 never opens. Inside a burst, a word presented with hb_wen other than 2'b11 is not taken, and the burst stays open.
- R7: hb_stop_n is low exactly while fifo_full is high.
- R8: While fifo_full is high, hb_rdy_n is high and no word is taken. When it clears, ready returns low and the word still held by the host is taken.
- R9: If hb_sel_n or hb_strb_n rises before the final word has been taken, the burst ends, hb_rdy_n goes high, and no word is taken until a new write opens.
- R10: A transfer with hb_rd_wr_n at 1 (read) never lowers hb_rdy_n and produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_sel_n | input | 1 | Chip select, active low |
| hb_strb_n | input | 1 | Data strobe, active low |
| hb_rd_wr_n | input | 1 | Direction: 1 read, 0 write |
| hb_mem_reg_n | input | 1 | Target space: 1 memory, 0 register |
| hb_wen | input | DATA_W/8 | Byte enables, all ones for a full word |
| hb_last_n | input | 1 | Low with the final word of a burst |
| hb_addr | input | ADDR_W | Word address, valid with each data word |
| hb_data | input | DATA_W | Write data |
| fifo_full | input | 1 | Downstream command queue full |
| hb_rdy_n | output | 1 | Data ready, active low |
| hb_stop_n | output | 1 | Stop request, active low |
| wr_en | output | 1 | Internal write strobe, one cycle per word |
| wr_addr | output | ADDR_W | Internal write address |
| wr_data | output | DATA_W | Internal write data |
| wr_mem | output | 1 | Internal target flag: 1 memory, 0 register |

## Verification
The bench builds the block with LAT = 3 and ADDR_W = 10. A latency of three puts two cycles in the wait state, so the wait counter actually counts and is compared against a latency that differs from the default. Narrowing the address makes the per-word address steps wrap inside the field, so wr_addr is checked as a field of exactly the configured width.

// File: rtl/hbw_pkg.sv
package hbw_pkg;

   typedef enum logic [2:0] {
      HBW_IDLE  = 3'd0,
      HBW_WAIT  = 3'd1,
      HBW_PRIME = 3'd2,
      HBW_XFER  = 3'd3,
      HBW_DONE  = 3'd4
   } hbw_state_e;

endpackage

// File: rtl/hbw_decode.sv
module hbw_decode #(
   parameter int WEN_W = 2
) (
   input  logic             sel_n,
   input  logic             strb_n,
   input  logic             rd_wr_n,
   input  logic [WEN_W-1:0] wen,
   output logic             active,
   output logic             word_ok,
   output logic             start_ok
);

   // both qualifiers low means the host is driving a transfer
   assign active   = !sel_n && !strb_n;
   // a full-width word needs every byte enable set
   assign word_ok  = active && (&wen);
   // only writes open a burst
   assign start_ok = word_ok && !rd_wr_n;

endmodule

// File: rtl/hbw_lat_timer.sv
module hbw_lat_timer #(
   parameter int LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);

   localparam int SPAN  = LAT - 1;
   localparam int CNT_W = (SPAN > 1) ? $clog2(SPAN) : 1;
   localparam int LAST  = SPAN - 1;

   if (LAT < 2) begin : g_bad_lat
      $error("hbw_lat_timer needs LAT of at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   assign done = run && (cnt_q == CNT_W'(LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run)
         cnt_q <= '0;
      else if (!done)
         cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/hbw_fsm.sv
module hbw_fsm #(
   parameter int LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic word_ok,
   input  logic start_ok,
   input  logic last_n,
   input  logic fifo_full,
   output logic cap,
   output logic rdy_n
);
   import hbw_pkg::*;

   if (LAT < 1) begin : g_bad_lat
      $error("hbw_fsm needs LAT of at least 1");
   end

   hbw_state_e state_q, state_d;
   logic       wait_done;

   // the wait state and its counter exist only when latency exceeds one
   if (LAT > 1) begin : g_timer
      hbw_lat_timer #(.LAT(LAT)) u_timer (
         .clk   (clk),
         .rst_n (rst_n),
         .run   (state_q == HBW_WAIT),
         .done  (wait_done)
      );
   end else begin : g_no_timer
      assign wait_done = 1'b0;
   end

   // a word is taken only in the transfer state with a full word and room below
   assign cap   = (state_q == HBW_XFER) && word_ok && !fifo_full;
   assign rdy_n = !(((state_q == HBW_PRIME) || (state_q == HBW_XFER)) && !fifo_full);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         HBW_IDLE: begin
            if (start_ok)
               state_d = (LAT == 1) ? HBW_PRIME : HBW_WAIT;
         end
         HBW_WAIT: begin
            if (!active)
               state_d = HBW_IDLE;
            else if (wait_done)
               state_d = HBW_PRIME;
         end
         HBW_PRIME: begin
            if (!active)
               state_d = HBW_IDLE;
            else
               state_d = HBW_XFER;
         end
         HBW_XFER: begin
            if (!active)
               state_d = HBW_IDLE;
            else if (cap && !last_n)
               state_d = HBW_DONE;
         end
         HBW_DONE: begin
            if (!active)
               state_d = HBW_IDLE;
         end
         default: state_d = HBW_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= HBW_IDLE;
      else
         state_q <= state_d;
   end

endmodule

// File: rtl/hbw_capture.sv
module hbw_capture #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   input  logic              mem,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              wr_mem
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wr_en <= 1'b0;
      else
         wr_en <= cap;
   end

   // payload registers load only on a taken word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_addr <= '0;
         wr_data <= '0;
         wr_mem  <= 1'b0;
      end else if (cap) begin
         wr_addr <= addr;
         wr_data <= data;
         wr_mem  <= mem;
      end
   end

endmodule

// File: rtl/hbw_slave.sv
module hbw_slave #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int LAT    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                hb_sel_n,
   input  logic                hb_strb_n,
   input  logic                hb_rd_wr_n,
   input  logic                hb_mem_reg_n,
   input  logic [DATA_W/8-1:0] hb_wen,
   input  logic                hb_last_n,
   input  logic [ADDR_W-1:0]   hb_addr,
   input  logic [DATA_W-1:0]   hb_data,
   input  logic                fifo_full,
   output logic                hb_rdy_n,
   output logic                hb_stop_n,
   output logic                wr_en,
   output logic [ADDR_W-1:0]   wr_addr,
   output logic [DATA_W-1:0]   wr_data,
   output logic                wr_mem
);

   localparam int WEN_W = DATA_W / 8;

   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data
      $error("hbw_slave needs DATA_W as a whole number of bytes");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("hbw_slave needs ADDR_W of at least 1");
   end

   logic active, word_ok, start_ok, cap;

   hbw_decode #(.WEN_W(WEN_W)) u_decode (
      .sel_n    (hb_sel_n),
      .strb_n   (hb_strb_n),
      .rd_wr_n  (hb_rd_wr_n),
      .wen      (hb_wen),
      .active   (active),
      .word_ok  (word_ok),
      .start_ok (start_ok)
   );

   hbw_fsm #(.LAT(LAT)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .word_ok   (word_ok),
      .start_ok  (start_ok),
      .last_n    (hb_last_n),
      .fifo_full (fifo_full),
      .cap       (cap),
      .rdy_n     (hb_rdy_n)
   );

   hbw_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap     (cap),
      .addr    (hb_addr),
      .data    (hb_data),
      .mem     (hb_mem_reg_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .wr_mem  (wr_mem)
   );

   // stop mirrors the downstream queue state
   assign hb_stop_n = !fifo_full;

endmodule

// File: rtl/hbw_checker.sv
module hbw_checker #(
   parameter int WEN_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hb_sel_n,
   input logic             hb_strb_n,
   input logic [WEN_W-1:0] hb_wen,
   input logic             hb_last_n,
   input logic             fifo_full,
   input logic             hb_rdy_n,
   input logic             wr_en
);

   // a write pulse follows a cycle in which ready was low
   assert_cap_in_rdy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(!hb_rdy_n));

   // the final word leaves ready high
   assert_last_rdy_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(!hb_last_n)) |-> hb_rdy_n);

   // partial byte enables never produce a write
   assert_no_partial_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hb_wen != '1) |=> !wr_en);

   // a full queue holds ready high
   assert_full_rdy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> hb_rdy_n);

   // a full queue blocks the take at that edge
   assert_full_no_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |=> !wr_en);

   // a released select or strobe blocks the take at that edge
   assert_release_no_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hb_sel_n || hb_strb_n) |=> !wr_en);

endmodule

bind hbw_slave hbw_checker #(.WEN_W(DATA_W/8)) u_hbw_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .hb_sel_n  (hb_sel_n),
   .hb_strb_n (hb_strb_n),
   .hb_wen    (hb_wen),
   .hb_last_n (hb_last_n),
   .fifo_full (fifo_full),
   .hb_rdy_n  (hb_rdy_n),
   .wr_en     (wr_en)
);

// File: tb/hbw_slave_test.sv
`timescale 1ns/1ps
module hbw_slave_test;

   localparam int ADDR_W = 10;
   localparam int DATA_W = 16;
   localparam int LAT    = 3;
   localparam int NV     = 4;

   // burst table: word count, address base, data base, memory flag, stalled word (-1 none)
   localparam int V_N     [NV] = '{1, 3, 5, 2};
   localparam int V_ABASE [NV] = '{12'h3F0, 12'h010, 12'h3FC, 12'h155};
   localparam int V_DBASE [NV] = '{16'hA5A5, 16'h1234, 16'hFFFF, 16'h0F0F};
   localparam int V_MEM   [NV] = '{1, 0, 1, 0};
   localparam int V_STALL [NV] = '{-1, 1, -1, 0};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              hb_sel_n = 1'b1, hb_strb_n = 1'b1, hb_rd_wr_n = 1'b1;
   logic              hb_mem_reg_n = 1'b0, hb_last_n = 1'b1, fifo_full = 1'b0;
   logic [1:0]        hb_wen = 2'b00;
   logic [ADDR_W-1:0] hb_addr = '0;
   logic [DATA_W-1:0] hb_data = '0;
   logic              hb_rdy_n, hb_stop_n, wr_en, wr_mem;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   hbw_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(LAT)) uut (
      .clk(clk), .rst_n(rst_n), .hb_sel_n(hb_sel_n), .hb_strb_n(hb_strb_n),
      .hb_rd_wr_n(hb_rd_wr_n), .hb_mem_reg_n(hb_mem_reg_n), .hb_wen(hb_wen),
      .hb_last_n(hb_last_n), .hb_addr(hb_addr), .hb_data(hb_data),
      .fifo_full(fifo_full), .hb_rdy_n(hb_rdy_n), .hb_stop_n(hb_stop_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mem(wr_mem)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic release_bus();
      hb_sel_n = 1'b1; hb_strb_n = 1'b1; hb_last_n = 1'b1;
      hb_rd_wr_n = 1'b1; hb_wen = 2'b00;
      tick();
   endtask

   // opens a write, checks latency, returns in the first transfer cycle
   task automatic open_burst(input logic mem);
      int lat;
      hb_sel_n = 1'b0; hb_strb_n = 1'b0; hb_rd_wr_n = 1'b0;
      hb_wen = 2'b11; hb_mem_reg_n = mem; hb_last_n = 1'b1;
      lat = 0;
      do begin
         tick(); lat++; #1;
      end while (hb_rdy_n && lat < 20);
      chk("R2 latency", 32'(lat), 32'(LAT));
      chk("R3 no take in first ready cycle", 32'(wr_en), 32'd0);
      tick();
   endtask

   function automatic logic [ADDR_W-1:0] w_addr(int v, int i);
      return ADDR_W'(V_ABASE[v] + i * 7);
   endfunction

   function automatic logic [DATA_W-1:0] w_data(int v, int i);
      return DATA_W'(V_DBASE[v] ^ (i * 16'h1111));
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk("R1 ready after reset", 32'(hb_rdy_n), 32'd1);
      chk("R1 stop after reset", 32'(hb_stop_n), 32'd1);
      chk("R1 write after reset", 32'(wr_en), 32'd0);
      rst_n = 1'b1;
      tick();

      // table-driven bursts
      for (int v = 0; v < NV; v++) begin
         int takes;
         takes = 0;
         open_burst(V_MEM[v][0]);
         for (int i = 0; i < V_N[v]; i++) begin
            hb_addr = w_addr(v, i);
            hb_data = w_data(v, i);
            hb_last_n = (i == V_N[v] - 1) ? 1'b0 : 1'b1;
            if (i == V_STALL[v]) begin
               fifo_full = 1'b1; #1;
               chk("R8 ready high while full", 32'(hb_rdy_n), 32'd1);
               chk("R7 stop low while full", 32'(hb_stop_n), 32'd0);
               tick(); #1;
               chk("R8 no take while full", 32'(wr_en), 32'd0);
               fifo_full = 1'b0; #1;
               chk("R8 ready back after full", 32'(hb_rdy_n), 32'd0);
               chk("R7 stop high after full", 32'(hb_stop_n), 32'd1);
            end
            tick(); #1;
            takes += int'(wr_en);
            chk("R4 write pulse", 32'(wr_en), 32'd1);
            chk("R4 address", 32'(wr_addr), 32'(w_addr(v, i)));
            chk("R4 data", 32'(wr_data), 32'(w_data(v, i)));
            chk("R4 memory flag", 32'(wr_mem), 32'(V_MEM[v]));
            if (i == V_N[v] - 1)
               chk("R5 ready high after final word", 32'(hb_rdy_n), 32'd1);
            else
               chk("R3 ready low between words", 32'(hb_rdy_n), 32'd0);
         end
         chk("R3 word count", 32'(takes), 32'(V_N[v]));
         for (int k = 0; k < 3; k++) begin
            tick(); #1;
            chk("R5 no ready before release", 32'(hb_rdy_n), 32'd1);
            chk("R5 no write before release", 32'(wr_en), 32'd0);
         end
         release_bus();
      end

      // partial enables at start
      hb_sel_n = 1'b0; hb_strb_n = 1'b0; hb_rd_wr_n = 1'b0; hb_wen = 2'b01;
      for (int k = 0; k < 6; k++) begin
         tick(); #1;
         chk("R6 partial enables keep ready high", 32'(hb_rdy_n), 32'd1);
         chk("R6 partial enables no write", 32'(wr_en), 32'd0);
      end
      release_bus();

      // read never opens
      hb_sel_n = 1'b0; hb_strb_n = 1'b0; hb_rd_wr_n = 1'b1; hb_wen = 2'b11;
      for (int k = 0; k < 6; k++) begin
         tick(); #1;
         chk("R10 read keeps ready high", 32'(hb_rdy_n), 32'd1);
         chk("R10 read no write", 32'(wr_en), 32'd0);
      end
      release_bus();

      // partial enables inside a burst
      open_burst(1'b0);
      hb_addr = 10'h2AA; hb_data = 16'hBEEF; hb_last_n = 1'b0; hb_wen = 2'b10;
      tick(); #1;
      chk("R6 partial word not taken", 32'(wr_en), 32'd0);
      chk("R6 burst stays open", 32'(hb_rdy_n), 32'd0);
      hb_wen = 2'b11;
      tick(); #1;
      chk("R6 full word taken", 32'(wr_en), 32'd1);
      chk("R6 full word data", 32'(wr_data), 32'hBEEF);
      chk("R5 ready high after final word", 32'(hb_rdy_n), 32'd1);
      release_bus();

      // abort by releasing strobe
      open_burst(1'b1);
      hb_addr = 10'h011; hb_data = 16'hC0DE;
      tick(); #1;
      chk("R9 word before abort", 32'(wr_en), 32'd1);
      hb_strb_n = 1'b1; hb_data = 16'hDEAD;
      for (int k = 0; k < 4; k++) begin
         tick(); #1;
         chk("R9 no write after abort", 32'(wr_en), 32'd0);
         chk("R9 ready high after abort", 32'(hb_rdy_n), 32'd1);
      end
      release_bus();

      // stop while idle
      fifo_full = 1'b1; #1;
      chk("R7 stop low when full in idle", 32'(hb_stop_n), 32'd0);
      fifo_full = 1'b0; #1;
      chk("R7 stop high when not full", 32'(hb_stop_n), 32'd1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule